// File: doc/BRIEF.md
# Linked Descriptor Chain Fetcher

This block sits beside one channel of a memory-to-memory copy engine and keeps the channel running through a list of transfers held in memory. Software starts it with one transfer description: control word, element count, source, destination and a pointer to the next record. The block presents these values to the transfer engine and pulses a start strobe. The engine itself is not part of this design. It is represented by a start pulse going out and a done pulse coming back.

When the engine reports done, the block looks at the channel's next-record pointer. A zero pointer means the list is finished, and the block raises its terminal-count flag. A non-zero pointer makes the block fetch an eight-word record from memory over a simple request/valid read port. It reads the words at consecutive word addresses, starting at the pointer value. Once the eighth word arrives, the block loads all channel registers from the record in a single cycle and starts the engine again.

A read error stops the list with the error flag set. An abort request stops the list with the abort flag set, and a record that has been fetched only in part is thrown away. The address-high words of a record are applied only when the address width is above 32 bits.

Top module: `desc_chain_fetcher`

## Requirements
- R1: After reset the block is idle: busy, rdReq, xferStart, tcFlag, errFlag and abortFlag are all 0.
- R2: A launch pulse while idle loads chCtrl, chSize, chSrc, chDst and chNext from the cfg inputs at the next clock edge. xferStart is high for exactly that following cycle, and busy stays high until the chain ends.
- R3: When xferDone arrives and chNext is zero, tcFlag is set, the block returns to idle and no read is issued.
- R4: When xferDone arrives and chNext is non-zero, the block issues eight reads, one at a time, at addresses chNext+4*i for i = 0..7 in increasing order. Each request holds rdReq and a stable rdAddr until the cycle in which rdValid is seen.
- R5: Record word i maps to the channel registers as follows: word 0 to chCtrl, word 1 to chSize (element count), word 2 to the source low part, word 4 to the destination low part, and word 6 to the next-pointer low part.
- R6: Words 3, 5 and 7 supply address bits 32 and up of source, destination and next pointer, and only when ADDR_W exceeds 32. With ADDR_W = 32 their contents have no effect on any register.
- R7: The channel registers change only in the cycle the eighth word is accepted. xferStart pulses in the following cycle. tcFlag stays 0 at every restart and is set only when the last record in the chain has completed.
- R8: A read answered with rdErr high sets errFlag and returns the block to idle. Every channel register keeps the value it had before that fetch began.
- R9: abortReq while busy sets abortFlag and returns the block to idle. It takes priority over an rdValid in the same cycle, and a partly fetched record leaves the channel registers unchanged.
- R10: A launch pulse while busy is ignored: the registers are not reloaded and no extra xferStart is produced.
- R11: At most one of tcFlag, errFlag and abortFlag is set at any time. All three stay set until the next accepted launch clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Load the cfg values and start the first transfer (taken only when idle) |
| cfgCtrl | input | 32 | Initial control word |
| cfgSize | input | 32 | Initial element count |
| cfgSrc | input | ADDR_W | Initial source address |
| cfgDst | input | ADDR_W | Initial destination address |
| cfgNext | input | ADDR_W | Initial next-record pointer |
| xferStart | output | 1 | One-cycle pulse that starts the transfer engine |
| xferDone | input | 1 | Transfer engine completed the current transfer |
| abortReq | input | 1 | Stop the chain |
| rdReq | output | 1 | Read request, held until rdValid |
| rdAddr | output | ADDR_W | Read byte address |
| rdValid | input | 1 | Read data or error is present this cycle |
| rdData | input | 32 | Read data word |
| rdErr | input | 1 | The read failed |
| chCtrl | output | 32 | Current control word |
| chSize | output | 32 | Current element count |
| chSrc | output | ADDR_W | Current source address |
| chDst | output | ADDR_W | Current destination address |
| chNext | output | ADDR_W | Current next-record pointer |
| busy | output | 1 | A chain is in progress |
| tcFlag | output | 1 | Chain ended at a null pointer |
| errFlag | output | 1 | Chain ended on a read error |
| abortFlag | output | 1 | Chain ended on abort |

## Verification
Chains of one, two and three records are run against read latencies of zero, one and two cycles. Every read address is compared in order with the expected list, which shows whether the walk covers the right records, in the right order, and tolerates a slow memory. A read error is injected at each of the eight word positions, and an abort is raised before each of the eight reads. These sweeps separate a commit that happens too early, or on a partial record, from one that happens only on the final word. Direct cases cover a null initial pointer, a launch while busy, and the clearing of flags. In every record the high words hold non-zero patterns, so any leak of those words into a 32-bit register shows up.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_FETCH = 2'd2
  } dcfState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             loadCfg;
    logic             capture;
    logic             commit;
    logic [IDX_W-1:0] idx;
  } dcfStrobes_t;
endpackage

// File: rtl/dcf_datapath.sv
module dcf_datapath
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dcfStrobes_t         st,
  input  logic [WORD_W-1:0]   cfgCtrl,
  input  logic [WORD_W-1:0]   cfgSize,
  input  logic [ADDR_W-1:0]   cfgSrc,
  input  logic [ADDR_W-1:0]   cfgDst,
  input  logic [ADDR_W-1:0]   cfgNext,
  input  logic [WORD_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   rdAddr,
  output logic                nextZero,
  output logic [WORD_W-1:0]   chCtrl,
  output logic [WORD_W-1:0]   chSize,
  output logic [ADDR_W-1:0]   chSrc,
  output logic [ADDR_W-1:0]   chDst,
  output logic [ADDR_W-1:0]   chNext
);
  localparam int LAST = DESC_WORDS - 1;

  logic [WORD_W-1:0] shadow [LAST];
  logic [WORD_W-1:0] word   [DESC_WORDS];

  // Holding registers for all words except the last, which is used straight off the read bus
  for (genvar i = 0; i < LAST; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadow[i] <= '0;
      end else if (st.capture && (st.idx == IDX_W'(i))) begin
        shadow[i] <= rdData;
      end
    end
    assign word[i] = shadow[i];
  end
  assign word[LAST] = rdData;

  // Join a low/high pair into an address; the high part only counts above 32 bits
  function automatic logic [ADDR_W-1:0] joinAddr(input logic [WORD_W-1:0] lo,
                                                 input logic [WORD_W-1:0] hi);
    logic [2*WORD_W-1:0] full;
    full = {hi, lo};
    return full[ADDR_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chCtrl <= '0;
      chSize <= '0;
      chSrc  <= '0;
      chDst  <= '0;
      chNext <= '0;
    end else if (st.loadCfg) begin
      chCtrl <= cfgCtrl;
      chSize <= cfgSize;
      chSrc  <= cfgSrc;
      chDst  <= cfgDst;
      chNext <= cfgNext;
    end else if (st.commit) begin
      chCtrl <= word[0];
      chSize <= word[1];
      chSrc  <= joinAddr(word[2], word[3]);
      chDst  <= joinAddr(word[4], word[5]);
      chNext <= joinAddr(word[6], word[7]);
    end
  end

  assign rdAddr   = chNext + ADDR_W'({st.idx, 2'b00});
  assign nextZero = (chNext == '0);
endmodule

// File: rtl/dcf_control.sv
module dcf_control
  import dcf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        launch,
  input  logic        xferDone,
  input  logic        abortReq,
  input  logic        rdValid,
  input  logic        rdErr,
  input  logic        nextZero,
  output dcfStrobes_t st,
  output logic        rdReq,
  output logic        xferStart,
  output logic        busy,
  output logic        tcFlag,
  output logic        errFlag,
  output logic        abortFlag
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  dcfState_e        state;
  logic [IDX_W-1:0] idx;
  logic             wordOk;

  assign wordOk     = (state == ST_FETCH) && !abortReq && rdValid && !rdErr;
  assign st.loadCfg = (state == ST_IDLE) && launch;
  assign st.capture = wordOk;
  assign st.commit  = wordOk && (idx == LAST_IDX);
  assign st.idx     = idx;

  assign rdReq = (state == ST_FETCH);
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      xferStart <= 1'b0;
      tcFlag    <= 1'b0;
      errFlag   <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      xferStart <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            tcFlag    <= 1'b0;
            errFlag   <= 1'b0;
            abortFlag <= 1'b0;
            state     <= ST_XFER;
            xferStart <= 1'b1;
          end
        end
        ST_XFER: begin
          if (abortReq) begin
            abortFlag <= 1'b1;
            state     <= ST_IDLE;
          end else if (xferDone) begin
            if (nextZero) begin
              tcFlag <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              idx   <= '0;
              state <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (abortReq) begin
            abortFlag <= 1'b1;
            state     <= ST_IDLE;
          end else if (rdValid) begin
            if (rdErr) begin
              errFlag <= 1'b1;
              state   <= ST_IDLE;
            end else if (idx == LAST_IDX) begin
              state     <= ST_XFER;
              xferStart <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_chain_fetcher.sv
module desc_chain_fetcher
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              launch,
  input  logic [31:0]       cfgCtrl,
  input  logic [31:0]       cfgSize,
  input  logic [ADDR_W-1:0] cfgSrc,
  input  logic [ADDR_W-1:0] cfgDst,
  input  logic [ADDR_W-1:0] cfgNext,
  output logic              xferStart,
  input  logic              xferDone,
  input  logic              abortReq,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  input  logic              rdErr,
  output logic [31:0]       chCtrl,
  output logic [31:0]       chSize,
  output logic [ADDR_W-1:0] chSrc,
  output logic [ADDR_W-1:0] chDst,
  output logic [ADDR_W-1:0] chNext,
  output logic              busy,
  output logic              tcFlag,
  output logic              errFlag,
  output logic              abortFlag
);
  dcfStrobes_t strobes;
  logic        nextZero;

  dcf_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .launch    (launch),
    .xferDone  (xferDone),
    .abortReq  (abortReq),
    .rdValid   (rdValid),
    .rdErr     (rdErr),
    .nextZero  (nextZero),
    .st        (strobes),
    .rdReq     (rdReq),
    .xferStart (xferStart),
    .busy      (busy),
    .tcFlag    (tcFlag),
    .errFlag   (errFlag),
    .abortFlag (abortFlag)
  );

  dcf_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .cfgCtrl  (cfgCtrl),
    .cfgSize  (cfgSize),
    .cfgSrc   (cfgSrc),
    .cfgDst   (cfgDst),
    .cfgNext  (cfgNext),
    .rdData   (rdData),
    .rdAddr   (rdAddr),
    .nextZero (nextZero),
    .chCtrl   (chCtrl),
    .chSize   (chSize),
    .chSrc    (chSrc),
    .chDst    (chDst),
    .chNext   (chNext)
  );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferStart,
  input logic              xferDone,
  input logic              abortReq,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              rdErr,
  input logic [31:0]       chCtrl,
  input logic              busy,
  input logic              tcFlag,
  input logic              errFlag,
  input logic              abortFlag
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid && !abortReq) |=> (rdReq && $stable(rdAddr)));

  // R4
  req_vs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !xferStart);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> busy);

  // R3
  tc_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcFlag) |-> $past(xferDone));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ($past(rdValid && rdErr) && $stable(chCtrl) && !busy));

  // R9
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortFlag) |-> ($past(abortReq) && $stable(chCtrl) && !busy));

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tcFlag, errFlag, abortFlag}));
endmodule

bind desc_chain_fetcher dcf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .xferStart (xferStart),
  .xferDone  (xferDone),
  .abortReq  (abortReq),
  .rdReq     (rdReq),
  .rdAddr    (rdAddr),
  .rdValid   (rdValid),
  .rdErr     (rdErr),
  .chCtrl    (chCtrl),
  .busy      (busy),
  .tcFlag    (tcFlag),
  .errFlag   (errFlag),
  .abortFlag (abortFlag)
);

// File: tb/desc_chain_fetcher_test.sv
module desc_chain_fetcher_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic launch = 1'b0;
  logic [31:0] cfgCtrl = '0, cfgSize = '0;
  logic [AW-1:0] cfgSrc = '0, cfgDst = '0, cfgNext = '0;
  logic xferStart, xferDone = 1'b0, abortReq = 1'b0;
  logic rdReq, rdValid = 1'b0, rdErr = 1'b0;
  logic [AW-1:0] rdAddr;
  logic [31:0] rdData = '0;
  logic [31:0] chCtrl, chSize;
  logic [AW-1:0] chSrc, chDst, chNext;
  logic busy, tcFlag, errFlag, abortFlag;

  desc_chain_fetcher #(.ADDR_W(AW)) uut (.*);

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench-side memory model state
  int chainLen = 1, latency = 0, waitCnt = 0, readCount = 0;
  logic [AW-1:0] errAddr = '1;
  logic [AW-1:0] addrLog [64];
  // transfer engine model state
  bit autoDone = 1;
  int starts = 0, earlyTc = 0, doneCnt = 0;

  // record k lives at k*0x100; word 6 links to the next record, word 7 holds nonzero filler
  function automatic logic [31:0] memWord(input logic [AW-1:0] a);
    int k, i;
    k = int'(a >> 8);
    i = int'((a >> 2) & 7);
    if (i == 6) return (k < chainLen) ? 32'((k + 1) << 8) : 32'h0;
    return {8'(k), 8'(i), 16'hC3A0 + 16'(i)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder
  initial forever begin
    @(negedge clk);
    if (rdValid) begin
      rdValid = 1'b0;
      rdErr = 1'b0;
      waitCnt = 0;
    end else if (rdReq) begin
      if (waitCnt >= latency) begin
        rdValid = 1'b1;
        rdData = memWord(rdAddr);
        rdErr = (rdAddr == errAddr);
        if (readCount < 64) addrLog[readCount] = rdAddr;
        readCount++;
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  // transfer engine model
  initial forever begin
    @(negedge clk);
    if (autoDone) xferDone = 1'b0;
    if (doneCnt > 0) begin
      doneCnt--;
      if (doneCnt == 0) xferDone = 1'b1;
    end
    if (xferStart) begin
      starts++;
      if (tcFlag) earlyTc++;
      if (autoDone) doneCnt = 2;
    end
  end

  task automatic doLaunch(input logic [31:0] c, input logic [AW-1:0] nxt);
    @(negedge clk);
    cfgCtrl = c; cfgSize = c ^ 32'h55; cfgSrc = c + 32'h10; cfgDst = c + 32'h20; cfgNext = nxt;
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  task automatic resetStats();
    readCount = 0; starts = 0; earlyTc = 0; errAddr = '1;
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !rdReq && !xferStart, "R1 idle outputs", {busy, rdReq, xferStart}, 0);
    chk(!tcFlag && !errFlag && !abortFlag, "R1 flags", {tcFlag, errFlag, abortFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3 null initial pointer
    resetStats();
    doLaunch(32'h1234_5600, '0);
    chk(xferStart == 1'b1, "R2 start pulse", xferStart, 1);
    chk(busy, "R2 busy", busy, 1);
    chk(chCtrl == 32'h1234_5600 && chSize == (32'h1234_5600 ^ 32'h55), "R2 ctrl/size load", chCtrl, 32'h1234_5600);
    chk(chSrc == 32'h1234_5610 && chDst == 32'h1234_5620 && chNext == 0, "R2 addr load", chSrc, 32'h1234_5610);
    @(negedge clk);
    chk(xferStart == 1'b0, "R2 start one cycle", xferStart, 0);
    waitIdle();
    chk(tcFlag && !busy, "R3 tc at null pointer", {tcFlag, busy}, 2);
    chk(readCount == 0, "R3 no reads", readCount, 0);

    // R4..R7 chain sweep over length and latency
    for (int L = 1; L <= 3; L++) begin
      for (int lat = 0; lat <= 2; lat++) begin
        resetStats();
        chainLen = L; latency = lat;
        doLaunch(32'hA000_0000 + 32'(L * 16 + lat), 32'h100);
        waitIdle();
        chk(readCount == 8 * L, "R4 read count", readCount, 8 * L);
        w = 0;
        for (int i = 0; i < 8 * L && i < 64; i++) begin
          logic [AW-1:0] ea;
          ea = AW'(((1 + i / 8) << 8) + 4 * (i % 8));
          if (addrLog[i] != ea) begin
            w++;
            chk(0, "R4 read address order", addrLog[i], ea);
          end
        end
        chk(w == 0, "R4 all addresses", w, 0);
        chk(chCtrl == memWord(AW'(L << 8)), "R5 ctrl from word0", chCtrl, memWord(AW'(L << 8)));
        chk(chSize == memWord(AW'((L << 8) + 4)), "R5 size from word1", chSize, memWord(AW'((L << 8) + 4)));
        chk(chSrc == memWord(AW'((L << 8) + 8)), "R6 src low only", chSrc, memWord(AW'((L << 8) + 8)));
        chk(chDst == memWord(AW'((L << 8) + 16)), "R6 dst low only", chDst, memWord(AW'((L << 8) + 16)));
        chk(chNext == 0, "R6 next high word ignored", chNext, 0);
        chk(starts == L + 1, "R7 restarts", starts, L + 1);
        chk(earlyTc == 0, "R7 no early tc", earlyTc, 0);
        chk(tcFlag && !errFlag && !abortFlag, "R7 tc at chain end", {tcFlag, errFlag, abortFlag}, 4);
      end
    end
    latency = 1; chainLen = 2;

    // R8 read error at each word position
    for (int k = 0; k < 8; k++) begin
      resetStats();
      errAddr = AW'(32'h100 + 4 * k);
      doLaunch(32'hE000_0000 + 32'(k), 32'h100);
      waitIdle();
      chk(errFlag && !tcFlag && !abortFlag, "R8 error flag", {tcFlag, errFlag, abortFlag}, 2);
      chk(chCtrl == 32'hE000_0000 + 32'(k) && chNext == 32'h100, "R8 regs kept", chCtrl, 32'hE000_0000 + 32'(k));
      chk(readCount == k + 1, "R8 stops at error", readCount, k + 1);
    end

    // R11 flags cleared by launch
    resetStats();
    doLaunch(32'h0000_0011, '0);
    chk(!errFlag && !tcFlag && !abortFlag, "R11 flags cleared", {tcFlag, errFlag, abortFlag}, 0);
    waitIdle();

    // R9 abort before each read
    for (int k = 0; k < 8; k++) begin
      resetStats();
      doLaunch(32'hB000_0000 + 32'(k), 32'h100);
      wait (rdReq && readCount == k);
      @(negedge clk);
      abortReq = 1'b1;
      @(negedge clk);
      abortReq = 1'b0;
      waitIdle();
      chk(abortFlag && !tcFlag && !errFlag, "R9 abort flag", {tcFlag, errFlag, abortFlag}, 1);
      chk(chCtrl == 32'hB000_0000 + 32'(k) && chNext == 32'h100, "R9 partial discarded", chCtrl, 32'hB000_0000 + 32'(k));
      chk(!busy && !rdReq, "R9 idle after abort", {busy, rdReq}, 0);
    end

    // R10 launch while busy
    resetStats();
    autoDone = 0;
    doLaunch(32'h0000_00A1, '0);
    doLaunch(32'h0000_00B2, 32'h300);
    repeat (2) @(negedge clk);
    chk(chCtrl == 32'h0000_00A1 && chNext == 0, "R10 no reload", chCtrl, 32'hA1);
    chk(starts == 1, "R10 no extra start", starts, 1);
    @(negedge clk);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    chk(tcFlag && !busy, "R10 first chain ends", {tcFlag, busy}, 2);
    autoDone = 1;

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule